// File: doc/BRIEF.md
# Disk DMA-Out Transfer Sequencer

This block moves halfwords from a transmit FIFO to a disk drive during a DMA write. Each halfword is fetched from the FIFO with a single read pulse and placed on a 16-bit output. The output is then held while the block plays one strobe cycle toward the drive. The strobe can take one of two styles, chosen by a control bit. The multiword style gives one write pulse per halfword, with programmable high and low cycle counts. The ultra style flips a strobe line once per halfword, so data advances on both of its edges.

The transfer pauses on its own whenever one of three things happens: the FIFO runs dry, the drive withdraws its DMA request, or software clears the pending bit. It picks up again without any software action once every cause has gone away. The drive ends the transfer by raising its interrupt line. The sequencer then drops acknowledge and raises a done flag. A halfword counter is visible to software and restarts from zero each time a new transfer is armed.

All pause and stop decisions are taken only between halfwords, so a strobe cycle is never cut short.

Top module: `dma_out_seq`

## Requirements
- R1: No FIFO read and no strobe occur unless ctl_pending and ctl_write are both 1. With either bit at 0, drv_ack stays 0 and the block stays idle.
- R2: At a halfword boundary the block pauses if the FIFO is empty, drv_req is 0 or ctl_pending is 0. While paused, fifo_rd_en and the strobes stay quiet and drv_ack stays 1.
- R3: A paused transfer resumes by itself at the first boundary where all three pause causes have cleared.
- R4: The transfer mode is sampled at the start of a transfer. With ctl_ultra=1, drv_wstb stays 0 and drv_ustb toggles once per halfword. With ctl_ultra=0, drv_wstb pulses once per halfword and drv_ustb does not change.
- R5: When drv_intr is 1 at a halfword boundary, the next cycle has drv_ack=0 and xfer_done=1. xfer_done stays 1 until ctl_pending is 0, and then the block returns to idle.
- R6: If drv_intr rises during a strobe, that halfword still completes with its full strobe timing before done is raised.
- R7: fifo_rd_en is high for exactly one cycle per halfword. The FIFO is show-ahead: fifo_data is sampled in the cycle where fifo_rd_en is high. That word appears on drv_data from the next cycle and is held until the next read.
- R8: hw_count gives the number of halfwords fetched since the last 0-to-1 change of ctl_pending. That change clears it, and a fetch in the same cycle counts as 1.
- R9: In multiword mode, drv_wstb rises in the cycle after the read pulse, is high for t_on cycles and then low for t_off cycles. A value of 0 in either count acts as 1. While data flows without a pause, read pulses come every t_on+t_off cycles.
- R10: In ultra mode, while data flows without a pause, drv_ustb toggles every t_on+t_off cycles, in the cycle after each read pulse.
- R11: After reset, drv_ack, drv_wstb, drv_ustb, fifo_rd_en and xfer_done are 0, and hw_count and drv_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_pending | input | 1 | Transfer armed by software |
| ctl_write | input | 1 | Direction bit, 1 = host to drive |
| ctl_ultra | input | 1 | Strobe style: 1 ultra, 0 multiword |
| t_on | input | TW | Strobe high / first-phase cycles |
| t_off | input | TW | Strobe low / second-phase cycles |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_data | input | 16 | Head word of the show-ahead FIFO |
| fifo_rd_en | output | 1 | Pop one halfword |
| drv_req | input | 1 | Drive DMA request |
| drv_intr | input | 1 | Drive interrupt, ends transfer |
| drv_ack | output | 1 | DMA acknowledge to drive |
| drv_wstb | output | 1 | Multiword write strobe |
| drv_ustb | output | 1 | Ultra toggling strobe |
| drv_data | output | 16 | Data to drive |
| xfer_done | output | 1 | Transfer ended by drive |
| hw_count | output | CW | Halfwords moved in this transfer |

## Verification
The bench builds the block with its default widths: 4-bit cycle counts and a 16-bit halfword counter. It sweeps t_on and t_off over every pair from 1 to 3 in both strobe modes. Each pair is a complete eight-word transfer that ends in an empty-FIFO pause and then a drive interrupt. This brings the exact strobe widths, the read spacing and the ultra toggle spacing under arithmetic check for each combination. Directed runs then pause the transfer through each of the three causes, raise the interrupt in the middle of a strobe, and re-arm the pending bit to confirm the counter restarts.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK,
        S_STB_ON,
        S_STB_OFF,
        S_PAUSE,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic active;    // pending and write direction both set
        logic go;        // active, drive requesting, FIFO not empty
        logic boundary;  // cycle where a new halfword may start
        logic fetch;     // halfword taken from FIFO this cycle
    } seq_flags_t;

    // phase length minus one, a zero count behaves as one cycle
    function automatic int unsigned span_m1(input int unsigned cycles);
        return (cycles == 0) ? 0 : cycles - 1;
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    // a loaded value of zero must be seen as expired in the next cycle
    p_timer_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> expired);

endmodule

// File: rtl/seq_hw_counter.sv
module seq_hw_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pending,
    input  logic          inc,
    output logic [CW-1:0] count
);
    logic pend_q;
    logic arm_edge;

    assign arm_edge = pending & ~pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            count  <= '0;
        end else begin
            pend_q <= pending;
            if (arm_edge)
                count <= inc ? CW'(1) : '0;
            else if (inc)
                count <= count + 1'b1;
        end
    end

    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (arm_edge && !inc) |=> (count == '0));

    p_cnt_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!arm_edge && !inc) |=> $stable(count));

endmodule

// File: rtl/dma_out_seq.sv
module dma_out_seq
    import dmaseq_pkg::*;
#(
    parameter int TW = 4,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_pending,
    input  logic          ctl_write,
    input  logic          ctl_ultra,
    input  logic [TW-1:0] t_on,
    input  logic [TW-1:0] t_off,
    input  logic          fifo_empty,
    input  logic [DW-1:0] fifo_data,
    output logic          fifo_rd_en,
    input  logic          drv_req,
    input  logic          drv_intr,
    output logic          drv_ack,
    output logic          drv_wstb,
    output logic          drv_ustb,
    output logic [DW-1:0] drv_data,
    output logic          xfer_done,
    output logic [CW-1:0] hw_count
);
    seq_state_e    st, st_nx;
    seq_flags_t    fl;
    logic          mode_ultra;
    logic          tmr_expired;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic [DW-1:0] data_q;
    logic          ustb_q;

    always_comb begin
        fl.active   = ctl_pending & ctl_write;
        fl.go       = fl.active & drv_req & ~fifo_empty;
        fl.boundary = (st == S_ACK) || (st == S_PAUSE) ||
                      (st == S_STB_OFF && tmr_expired);
        fl.fetch    = fl.boundary & ~drv_intr & fl.go;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:    if (fl.active && drv_req) st_nx = S_ACK;
            S_ACK, S_PAUSE, S_STB_OFF: begin
                if (fl.boundary) begin
                    if (drv_intr)      st_nx = S_DONE;
                    else if (fl.fetch) st_nx = S_STB_ON;
                    else               st_nx = S_PAUSE;
                end
            end
            S_STB_ON:  if (tmr_expired) st_nx = S_STB_OFF;
            S_DONE:    if (!ctl_pending) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (fl.fetch) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(span_m1(int'(t_on)));
        end else if (st == S_STB_ON && tmr_expired) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(span_m1(int'(t_off)));
        end
    end

    seq_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    seq_hw_counter #(.CW(CW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .pending (ctl_pending),
        .inc     (fl.fetch),
        .count   (hw_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            mode_ultra <= 1'b0;
            data_q     <= '0;
            ustb_q     <= 1'b0;
        end else begin
            st <= st_nx;
            if (st == S_IDLE && st_nx == S_ACK)
                mode_ultra <= ctl_ultra;
            if (fl.fetch) begin
                data_q <= fifo_data;
                if (mode_ultra)
                    ustb_q <= ~ustb_q;
            end
        end
    end

    assign fifo_rd_en = fl.fetch;
    assign drv_ack    = (st == S_ACK) || (st == S_STB_ON) ||
                        (st == S_STB_OFF) || (st == S_PAUSE);
    assign drv_wstb   = (st == S_STB_ON) && !mode_ultra;
    assign drv_ustb   = ustb_q;
    assign drv_data   = data_q;
    assign xfer_done  = (st == S_DONE);

    p_rd_needs_go_r1: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> (ctl_pending && ctl_write && drv_req && !fifo_empty));

    p_rd_single_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> !fifo_rd_en);

    p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_en |=> $stable(drv_data));

    p_done_noack_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> !drv_ack);

    p_wstb_under_ack_r4: assert property (@(posedge clk) disable iff (rst)
        drv_wstb |-> drv_ack);

    p_ustb_only_on_read_r4: assert property (@(posedge clk) disable iff (rst)
        !fifo_rd_en |=> $stable(drv_ustb));

    p_pause_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_PAUSE) |-> (!drv_wstb && drv_ack));

endmodule

// File: tb/tb_dma_out_seq.sv
module tb_dma_out_seq;
    localparam int TW = 4;
    localparam int CW = 16;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_pending = 1'b0, ctl_write = 1'b0, ctl_ultra = 1'b0;
    logic [TW-1:0] t_on = 4'd1, t_off = 4'd1;
    logic          fifo_empty;
    logic [15:0]   fifo_data;
    logic          fifo_rd_en;
    logic          drv_req = 1'b0, drv_intr = 1'b0;
    logic          drv_ack, drv_wstb, drv_ustb, xfer_done;
    logic [15:0]   drv_data;
    logic [CW-1:0] hw_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_out_seq #(.TW(TW), .CW(CW), .DW(16)) dut (
        .clk(clk), .rst(rst), .ctl_pending(ctl_pending), .ctl_write(ctl_write),
        .ctl_ultra(ctl_ultra), .t_on(t_on), .t_off(t_off),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd_en(fifo_rd_en),
        .drv_req(drv_req), .drv_intr(drv_intr), .drv_ack(drv_ack),
        .drv_wstb(drv_wstb), .drv_ustb(drv_ustb), .drv_data(drv_data),
        .xfer_done(xfer_done), .hw_count(hw_count)
    );

    // show-ahead FIFO model; word k since reset is C300 + k*0105
    logic [5:0] rd_ptr, wr_ptr;
    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = 16'hC300 + 16'(rd_ptr) * 16'h0105;
    always @(posedge clk) begin
        if (rst) rd_ptr <= '0;
        else if (fifo_rd_en) rd_ptr <= rd_ptr + 1'b1;
    end

    int checks = 0, errors = 0;
    int cyc = 0, rdcnt = 0, tgl = 0;
    int last_rd = -1, last_tgl = -1, wrun = 0;
    bit prev_rd = 0, prev_ustb = 0, prev_w = 0, cont = 0, finished = 0;
    logic [15:0] exp_word;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor, sampled at falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            prev_rd = 0; prev_w = 0; wrun = 0; prev_ustb = drv_ustb;
        end else begin
            if (prev_rd) chk(drv_data == exp_word, "R7 data", drv_data, exp_word);
            if (fifo_rd_en) begin
                if (prev_rd) chk(0, "R7 double read", 1, 0);
                exp_word = 16'hC300 + 16'(rd_ptr) * 16'h0105;
                rdcnt++;
                if (cont && last_rd >= 0)
                    chk(cyc - last_rd == int'(t_on) + int'(t_off), "R9 read spacing",
                        cyc - last_rd, int'(t_on) + int'(t_off));
                last_rd = cyc;
            end
            if (drv_wstb) begin
                if (!prev_w && !prev_rd) chk(0, "R9 wstb not after read", 0, 1);
                wrun++;
            end else if (prev_w) begin
                chk(wrun == int'(t_on), "R9 wstb width", wrun, int'(t_on));
                chk(!ctl_ultra, "R4 wstb in ultra", 1, 0);
                wrun = 0;
            end
            if (drv_ustb != prev_ustb) begin
                tgl++;
                chk(ctl_ultra && prev_rd, "R4 ustb toggle", ctl_ultra, 1);
                if (cont && last_tgl >= 0)
                    chk(cyc - last_tgl == int'(t_on) + int'(t_off), "R10 toggle spacing",
                        cyc - last_tgl, int'(t_on) + int'(t_off));
                last_tgl = cyc;
            end
            prev_rd = fifo_rd_en; prev_w = drv_wstb; prev_ustb = drv_ustb;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ctl_pending = 0; ctl_write = 0; drv_req = 0; drv_intr = 0;
        wr_ptr = '0;
        repeat (2) @(negedge clk);
        rst = 0;
        rdcnt = 0; tgl = 0; last_rd = -1; last_tgl = -1;
    endtask

    task automatic wait_rd(input int n);
        for (int i = 0; i < 300 && rdcnt < n; i++) @(negedge clk);
    endtask

    task automatic sweep(input bit ultra, input int on, input int off);
        do_reset();
        t_on = TW'(on); t_off = TW'(off); ctl_ultra = ultra;
        wr_ptr = 6'd8;
        cont = 1;
        ctl_write = 1; drv_req = 1; ctl_pending = 1;
        wait_rd(8);
        repeat (on + off + 3) @(negedge clk);
        cont = 0;
        chk(rdcnt == 8, "R7 read count", rdcnt, 8);
        chk(hw_count == 8, "R8 count", hw_count, 8);
        chk(drv_ack == 1 && !xfer_done, "R2 empty pause", drv_ack, 1);
        chk(tgl == (ultra ? 8 : 0), "R4 toggles", tgl, ultra ? 8 : 0);
        drv_intr = 1;
        repeat (2) @(negedge clk);
        chk(xfer_done == 1 && drv_ack == 0, "R5 done", xfer_done, 1);
        ctl_pending = 0; drv_intr = 0;
        @(negedge clk);
        @(negedge clk);
        chk(xfer_done == 0 && drv_ack == 0, "R5 back to idle", xfer_done, 0);
    endtask

    initial begin
        do_reset();
        chk(!drv_ack && !drv_wstb && !drv_ustb && !fifo_rd_en && !xfer_done,
            "R11 outputs", drv_ack, 0);
        chk(hw_count == 0 && drv_data == 0, "R11 count/data", hw_count, 0);

        // R1: one of the two arming bits missing
        wr_ptr = 6'd4; drv_req = 1; ctl_pending = 1; ctl_write = 0;
        repeat (10) @(negedge clk);
        chk(rdcnt == 0 && !drv_ack, "R1 write=0", rdcnt, 0);
        ctl_pending = 0; ctl_write = 1;
        repeat (10) @(negedge clk);
        chk(rdcnt == 0 && !drv_ack, "R1 pending=0", rdcnt, 0);

        for (int u = 0; u < 2; u++)
            for (int a = 1; a <= 3; a++)
                for (int b = 1; b <= 3; b++)
                    sweep(u[0], a, b);

        // R2/R3 request drop, pending clear, R8 re-arm
        do_reset();
        t_on = 4'd2; t_off = 4'd2; ctl_ultra = 0; wr_ptr = 6'd10;
        ctl_write = 1; drv_req = 1; ctl_pending = 1;
        wait_rd(3);
        @(negedge clk); drv_req = 0;
        repeat (12) @(negedge clk);
        chk(rdcnt == 3 && drv_ack, "R2 req drop pause", rdcnt, 3);
        drv_req = 1;
        wait_rd(6);
        chk(rdcnt == 6, "R3 resume after req", rdcnt, 6);
        @(negedge clk); ctl_pending = 0;
        repeat (12) @(negedge clk);
        chk(rdcnt == 6 && drv_ack, "R2 pending clear pause", rdcnt, 6);
        ctl_pending = 1;
        wait_rd(10);
        chk(rdcnt == 10, "R3 resume after pending", rdcnt, 10);
        chk(hw_count == 4, "R8 cleared on re-arm", hw_count, 4);
        repeat (8) @(negedge clk);
        chk(drv_ack && fifo_empty, "R2 empty pause", drv_ack, 1);
        wr_ptr = 6'd12;
        wait_rd(12);
        chk(rdcnt == 12, "R3 resume after refill", rdcnt, 12);

        // R6: interrupt mid-strobe, t_on=3 t_off=2
        do_reset();
        t_on = 4'd3; t_off = 4'd2; ctl_ultra = 0; wr_ptr = 6'd4;
        ctl_write = 1; drv_req = 1; ctl_pending = 1;
        wait_rd(1);
        @(negedge clk); drv_intr = 1;
        repeat (3) @(negedge clk);
        chk(!xfer_done && drv_ack, "R6 strobe not cut", xfer_done, 0);
        repeat (2) @(negedge clk);
        chk(xfer_done && !drv_ack, "R6 done after word", xfer_done, 1);
        chk(rdcnt == 1, "R6 no further read", rdcnt, 1);
        drv_intr = 0; ctl_pending = 0;
        repeat (3) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule